// File: doc/BRIEF.md
# Privilege Stack Trap Unit

This block holds the machine status state that a processor core changes when it takes a trap and when it comes back from one. It keeps three stacked levels, and each level is a pair of a privilege mode and an interrupt enable. Level 0 is the mode the core runs in now. Taking a trap pushes the stack down by one level and enters machine mode with interrupts off. Returning pops the stack back up, and the emptied deepest level is refilled with user mode and interrupts enabled.

On trap entry the unit also latches the trap cause and the interrupted program counter. It computes a vector address from the privilege that was in force just before the trap, and it drops any outstanding load reservation. Software can write the status word through a CSR write port. The enable, pending and state bits are taken as written. Each privilege field changes only when the written code is a legal mode. The summary-dirty bit follows the floating-point and extension state fields.

Every update is registered, so results show on the outputs one clock after the strobe.

Top module: `priv_trap_stack`

## Requirements
- R1: After reset the status word reads 0x0000064B. This is level 0 machine (code 3) with enable 0, levels 1 and 2 supervisor (code 1) with enable 0, and memory privilege machine. Vector, saved PC, cause and reservation all read zero.
- R2: In the status word, level i uses bits [3i+1:3i] for privilege and bit 3i+2 for its enable. The mode codes are user 0, supervisor 1 and machine 3. On a trap strobe, level 2 takes level 1, level 1 takes level 0, and level 0 becomes machine with enable 0. The memory privilege field, bits [10:9], becomes machine.
- R3: On a trap strobe the vector output becomes 0x40 times the level 0 privilege code held before the trap. The possible values are 0x00, 0x40 and 0xC0.
- R4: On a trap strobe the saved-PC output takes the trap PC and the cause output takes the trap cause. Without a trap both outputs hold their values.
- R5: On a return strobe, level 0 takes level 1 and level 1 takes level 2. Level 2 becomes user with enable 1. Vector, saved PC and cause do not change.
- R6: A status write copies these bits from the data as written: the level enables (bits 2, 5, 8), machine software interrupt pending (bit 11), supervisor software interrupt pending (bit 12), timer enable (bit 13), floating-point state (bits [15:14]) and extension state (bits [17:16]). Bits not named in any requirement read zero.
- R7: On a status write, each privilege field (levels 0 to 2 and memory privilege) is updated only if the written code is 0, 1 or 3. If the code is 2, that field keeps its old value.
- R8: Status bit 31 reads 1 exactly when the floating-point state or the extension state field is 3.
- R9: A reservation-set pulse makes the reservation output 1. A trap strobe clears it, and the trap wins when both arrive in the same cycle.
- R10: When strobes arrive in the same cycle, trap beats return, and return beats a status write. The losing operations have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap entry strobe |
| trapCause | input | XLEN | Cause code of the trap |
| trapPc | input | XLEN | PC of the interrupted instruction |
| retValid | input | 1 | Trap return strobe |
| csrWrEn | input | 1 | Status word write strobe |
| csrWrData | input | 32 | Status word write data |
| resvSet | input | 1 | Load reservation acquired |
| status | output | 32 | Status word |
| vecAddr | output | XLEN | Trap vector address |
| epc | output | XLEN | Saved exception PC |
| cause | output | XLEN | Latched trap cause |
| resvValid | output | 1 | Load reservation outstanding |

## Verification
A wrong shift or refill in the stack shows at the status port one clock after the trap or return strobe. An error in a deep level can stay hidden until later returns pop it up into level 0, so the bench runs a full trap chain and unwinds it through three returns. A bad legality filter or dirty-bit computation shows in the status word the cycle after the write. A vector computed from the wrong privilege shows at the vector port as soon as a trap is taken from user, supervisor or machine mode.

// File: rtl/priv_stack_pkg.sv
package priv_stack_pkg;
  localparam int STACK_DEPTH = 3;
  localparam int PRIV_W      = 2;
  localparam int STAT_W      = 32;
  localparam int LVL_W       = PRIV_W + 1;
  localparam int MPRV_LSB    = STACK_DEPTH * LVL_W;
  localparam int MSIP_BIT    = MPRV_LSB + PRIV_W;
  localparam int SSIP_BIT    = MSIP_BIT + 1;
  localparam int TIE_BIT     = SSIP_BIT + 1;
  localparam int FS_LSB      = TIE_BIT + 1;
  localparam int XS_LSB      = FS_LSB + 2;
  localparam int SD_BIT      = STAT_W - 1;
  localparam int VEC_SHIFT   = 6;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic              ie;
    logic [PRIV_W-1:0] prv;
  } lvl_t;

  typedef struct packed {
    logic                 doTrap;
    logic                 doRet;
    logic                 doWrite;
    logic [STACK_DEPTH:0] privOk;
  } cmd_t;

  function automatic logic privLegal(input logic [PRIV_W-1:0] code);
    return (code == PRIV_U) || (code == PRIV_S) || (code == PRIV_M);
  endfunction
endpackage

// File: rtl/priv_stack_ctrl.sv
module priv_stack_ctrl
  import priv_stack_pkg::*;
(
  input  logic              trapValid,
  input  logic              retValid,
  input  logic              csrWrEn,
  input  logic [STAT_W-1:0] csrWrData,
  output cmd_t              cmd
);
  logic [STACK_DEPTH:0] okVec;

  for (genvar g = 0; g < STACK_DEPTH; g++) begin : gLvlOk
    assign okVec[g] = privLegal(csrWrData[g*LVL_W +: PRIV_W]);
  end
  assign okVec[STACK_DEPTH] = privLegal(csrWrData[MPRV_LSB +: PRIV_W]);

  always_comb begin
    cmd.doTrap  = trapValid;
    cmd.doRet   = retValid & ~trapValid;
    cmd.doWrite = csrWrEn & ~trapValid & ~retValid;
    cmd.privOk  = okVec;
  end
endmodule

// File: rtl/priv_stack_dp.sv
module priv_stack_dp
  import priv_stack_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic [STAT_W-1:0] csrWrData,
  input  logic [XLEN-1:0]   trapCause,
  input  logic [XLEN-1:0]   trapPc,
  input  logic              resvSet,
  output logic [STAT_W-1:0] status,
  output logic [XLEN-1:0]   vecAddr,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic              resvValid
);
  lvl_t              stack    [STACK_DEPTH];
  lvl_t              stackNxt [STACK_DEPTH];
  logic [PRIV_W-1:0] memPriv, memPrivNxt;
  logic              swIntM, swIntS, timerEn;
  logic [1:0]        fsState, xsState;

  always_comb begin
    stackNxt = stack;
    if (cmd.doTrap) begin
      stackNxt[0] = '{ie: 1'b0, prv: PRIV_M};
      for (int i = 1; i < STACK_DEPTH; i++) stackNxt[i] = stack[i-1];
    end else if (cmd.doRet) begin
      for (int i = 0; i < STACK_DEPTH - 1; i++) stackNxt[i] = stack[i+1];
      stackNxt[STACK_DEPTH-1] = '{ie: 1'b1, prv: PRIV_U};
    end else if (cmd.doWrite) begin
      for (int i = 0; i < STACK_DEPTH; i++) begin
        stackNxt[i].ie = csrWrData[i*LVL_W + PRIV_W];
        if (cmd.privOk[i]) stackNxt[i].prv = csrWrData[i*LVL_W +: PRIV_W];
      end
    end
  end

  always_comb begin
    memPrivNxt = memPriv;
    if (cmd.doTrap) memPrivNxt = PRIV_M;
    else if (cmd.doWrite && cmd.privOk[STACK_DEPTH])
      memPrivNxt = csrWrData[MPRV_LSB +: PRIV_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stack[0] <= '{ie: 1'b0, prv: PRIV_M};
      for (int i = 1; i < STACK_DEPTH; i++) stack[i] <= '{ie: 1'b0, prv: PRIV_S};
      memPriv <= PRIV_M;
    end else begin
      stack   <= stackNxt;
      memPriv <= memPrivNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swIntM  <= 1'b0;
      swIntS  <= 1'b0;
      timerEn <= 1'b0;
      fsState <= 2'd0;
      xsState <= 2'd0;
    end else if (cmd.doWrite) begin
      swIntM  <= csrWrData[MSIP_BIT];
      swIntS  <= csrWrData[SSIP_BIT];
      timerEn <= csrWrData[TIE_BIT];
      fsState <= csrWrData[FS_LSB +: 2];
      xsState <= csrWrData[XS_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecAddr <= '0;
      epc     <= '0;
      cause   <= '0;
    end else if (cmd.doTrap) begin
      vecAddr <= XLEN'(stack[0].prv) << VEC_SHIFT;
      epc     <= trapPc;
      cause   <= trapCause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resvValid <= 1'b0;
    else if (cmd.doTrap)  resvValid <= 1'b0;
    else if (resvSet)     resvValid <= 1'b1;
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < STACK_DEPTH; i++) status[i*LVL_W +: LVL_W] = stack[i];
    status[MPRV_LSB +: PRIV_W] = memPriv;
    status[MSIP_BIT]           = swIntM;
    status[SSIP_BIT]           = swIntS;
    status[TIE_BIT]            = timerEn;
    status[FS_LSB +: 2]        = fsState;
    status[XS_LSB +: 2]        = xsState;
    status[SD_BIT]             = (&fsState) | (&xsState);
  end
endmodule

// File: rtl/priv_trap_stack.sv
module priv_trap_stack
  import priv_stack_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapValid,
  input  logic [XLEN-1:0]   trapCause,
  input  logic [XLEN-1:0]   trapPc,
  input  logic              retValid,
  input  logic              csrWrEn,
  input  logic [STAT_W-1:0] csrWrData,
  input  logic              resvSet,
  output logic [STAT_W-1:0] status,
  output logic [XLEN-1:0]   vecAddr,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic              resvValid
);
  cmd_t cmd;

  priv_stack_ctrl ctrl_i (
    .trapValid (trapValid),
    .retValid  (retValid),
    .csrWrEn   (csrWrEn),
    .csrWrData (csrWrData),
    .cmd       (cmd)
  );

  priv_stack_dp #(.XLEN(XLEN)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .csrWrData (csrWrData),
    .trapCause (trapCause),
    .trapPc    (trapPc),
    .resvSet   (resvSet),
    .status    (status),
    .vecAddr   (vecAddr),
    .epc       (epc),
    .cause     (cause),
    .resvValid (resvValid)
  );
endmodule

// File: rtl/priv_trap_stack_chk.sv
module priv_trap_stack_chk
  import priv_stack_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapValid,
  input logic [XLEN-1:0]   trapCause,
  input logic [XLEN-1:0]   trapPc,
  input logic              retValid,
  input logic              csrWrEn,
  input logic [STAT_W-1:0] csrWrData,
  input logic              resvSet,
  input logic [STAT_W-1:0] status,
  input logic [XLEN-1:0]   vecAddr,
  input logic [XLEN-1:0]   epc,
  input logic [XLEN-1:0]   cause,
  input logic              resvValid
);
  localparam int TOP_LSB = (STACK_DEPTH - 1) * LVL_W;

  AST_TRAP_ENTER_M: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> status[0 +: LVL_W] == {1'b0, PRIV_M} && status[MPRV_LSB +: PRIV_W] == PRIV_M); // R2

  AST_TRAP_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> status[LVL_W +: LVL_W] == $past(status[0 +: LVL_W])); // R2

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> vecAddr == (XLEN'($past(status[0 +: PRIV_W])) << VEC_SHIFT)); // R3

  AST_TRAP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> epc == $past(trapPc) && cause == $past(trapCause)); // R4

  AST_NO_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> $stable(epc) && $stable(cause) && $stable(vecAddr)); // R4

  AST_RET_POP: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !trapValid |=> status[TOP_LSB +: LVL_W] == {1'b1, PRIV_U}
      && status[0 +: LVL_W] == $past(status[LVL_W +: LVL_W])); // R5

  AST_ILLEGAL_PRIV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    csrWrEn && !trapValid && !retValid && csrWrData[0 +: PRIV_W] == 2'b10
      |=> status[0 +: PRIV_W] == $past(status[0 +: PRIV_W])); // R7

  AST_TRAP_DROPS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !resvValid); // R9
endmodule

bind priv_trap_stack priv_trap_stack_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/priv_trap_stack_tb.sv
`timescale 1ns/1ps
module priv_trap_stack_tb_top;
  localparam int XLEN = 32;

  typedef struct {
    logic [31:0]     stat;
    logic [XLEN-1:0] vec;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] cs;
    logic            resv;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            trapValid = 1'b0, retValid = 1'b0, csrWrEn = 1'b0, resvSet = 1'b0;
  logic [XLEN-1:0] trapCause = '0, trapPc = '0;
  logic [31:0]     csrWrData = '0;
  logic [31:0]     status;
  logic [XLEN-1:0] vecAddr, epc, cause;
  logic            resvValid;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sbQ[$];

  logic [1:0] mPrv [3];
  logic       mIe  [3];
  logic [1:0] mMp, mFs, mXs;
  logic       mMsip, mSsip, mTie, mResv;
  logic [XLEN-1:0] mVec, mEpc, mCause;

  always #2 clk = ~clk;

  priv_trap_stack #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapCause(trapCause),
    .trapPc(trapPc), .retValid(retValid), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .resvSet(resvSet), .status(status), .vecAddr(vecAddr), .epc(epc),
    .cause(cause), .resvValid(resvValid)
  );

  function automatic logic [31:0] packStat();
    logic [31:0] w = '0;
    for (int i = 0; i < 3; i++) begin
      w[3*i +: 2] = mPrv[i];
      w[3*i + 2]  = mIe[i];
    end
    w[10:9] = mMp; w[11] = mMsip; w[12] = mSsip; w[13] = mTie;
    w[15:14] = mFs; w[17:16] = mXs;
    w[31] = (mFs == 2'd3) || (mXs == 2'd3);
    return w;
  endfunction

  function automatic logic [31:0] mkWord(input logic [1:0] p0, input logic e0,
      input logic [1:0] p1, input logic e1, input logic [1:0] p2, input logic e2,
      input logic [1:0] mp, input logic msip, input logic ssip, input logic tie,
      input logic [1:0] fs, input logic [1:0] xs);
    logic [31:0] w = '0;
    w[1:0] = p0; w[2] = e0; w[4:3] = p1; w[5] = e1; w[7:6] = p2; w[8] = e2;
    w[10:9] = mp; w[11] = msip; w[12] = ssip; w[13] = tie;
    w[15:14] = fs; w[17:16] = xs;
    w[30:18] = 13'h1FFF;
    return w;
  endfunction

  task automatic modelReset();
    mPrv[0] = 2'd3; mPrv[1] = 2'd1; mPrv[2] = 2'd1;
    for (int i = 0; i < 3; i++) mIe[i] = 1'b0;
    mMp = 2'd3; mFs = '0; mXs = '0; mMsip = 0; mSsip = 0; mTie = 0; mResv = 0;
    mVec = '0; mEpc = '0; mCause = '0;
  endtask

  task automatic pushExp(input string tag);
    exp_t e;
    e.stat = packStat(); e.vec = mVec; e.pc = mEpc; e.cs = mCause;
    e.resv = mResv; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic doOp(input bit tr, input bit rt, input bit wr, input logic [31:0] data,
                      input logic [XLEN-1:0] cs, input logic [XLEN-1:0] pc,
                      input bit rs, input string tag);
    @(negedge clk);
    trapValid = tr; retValid = rt; csrWrEn = wr; csrWrData = data;
    trapCause = cs; trapPc = pc; resvSet = rs;
    if (tr) begin
      mVec = XLEN'(mPrv[0]) << 6; mEpc = pc; mCause = cs;
      mPrv[2] = mPrv[1]; mIe[2] = mIe[1];
      mPrv[1] = mPrv[0]; mIe[1] = mIe[0];
      mPrv[0] = 2'd3;    mIe[0] = 1'b0;
      mMp = 2'd3; mResv = 1'b0;
    end else begin
      if (rt) begin
        mPrv[0] = mPrv[1]; mIe[0] = mIe[1];
        mPrv[1] = mPrv[2]; mIe[1] = mIe[2];
        mPrv[2] = 2'd0;    mIe[2] = 1'b1;
      end else if (wr) begin
        for (int i = 0; i < 3; i++) begin
          mIe[i] = data[3*i + 2];
          if (data[3*i +: 2] != 2'd2) mPrv[i] = data[3*i +: 2];
        end
        if (data[10:9] != 2'd2) mMp = data[10:9];
        mMsip = data[11]; mSsip = data[12]; mTie = data[13];
        mFs = data[15:14]; mXs = data[17:16];
      end
      if (rs) mResv = 1'b1;
    end
    @(negedge clk);
    trapValid = 0; retValid = 0; csrWrEn = 0; resvSet = 0;
    pushExp(tag);
  endtask

  task automatic cmpOne(input string tag, input string what,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        cmpOne(e.tag, "status", XLEN'(status), XLEN'(e.stat));
        cmpOne(e.tag, "vector", vecAddr, e.vec);
        cmpOne(e.tag, "epc", epc, e.pc);
        cmpOne(e.tag, "cause", cause, e.cs);
        cmpOne(e.tag, "resv", XLEN'(resvValid), XLEN'(e.resv));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushExp("R1 reset state");
    doOp(0, 0, 0, '0, '0, '0, 1, "R9 reservation set");
    // R6 R7 R8: level1 code 2 is illegal and kept, floating-point state 3 sets dirty
    doOp(0, 0, 1, mkWord(2'd0, 1, 2'd2, 1, 2'd3, 0, 2'd1, 1, 0, 1, 2'd3, 2'd0),
         '0, '0, 0, "R6 R7 R8 write");
    doOp(1, 0, 0, '0, 32'd5, 32'h1000, 0, "R2 R3 R4 R9 trap from user");
    doOp(0, 0, 0, '0, 32'd9, 32'h2000, 0, "R4 idle hold");
    doOp(0, 0, 1, mkWord(2'd1, 1, 2'd0, 1, 2'd1, 1, 2'd0, 0, 1, 0, 2'd0, 2'd0),
         '0, '0, 1, "R6 R7 write supervisor");
    doOp(1, 0, 0, '0, 32'h8000_0007, 32'h3004, 0, "R2 R3 trap from supervisor");
    doOp(1, 0, 0, '0, 32'd2, 32'h4008, 0, "R2 R3 trap from machine");
    doOp(0, 1, 0, '0, '0, '0, 0, "R5 return 1");
    doOp(0, 1, 0, '0, '0, '0, 0, "R5 return 2");
    doOp(0, 1, 0, '0, '0, '0, 0, "R5 return 3");
    doOp(0, 0, 1, mkWord(2'd2, 0, 2'd2, 0, 2'd2, 1, 2'd2, 0, 0, 0, 2'd2, 2'd3),
         '0, '0, 0, "R7 R8 all illegal codes");
    doOp(0, 0, 1, mkWord(2'd3, 0, 2'd0, 0, 2'd1, 0, 2'd0, 0, 0, 0, 2'd2, 2'd1),
         '0, '0, 0, "R8 not dirty");
    doOp(0, 0, 1, mkWord(2'd0, 1, 2'd1, 0, 2'd3, 1, 2'd1, 1, 1, 1, 2'd1, 2'd2),
         '0, '0, 1, "R6 R9 write all legal");
    doOp(1, 1, 1, mkWord(2'd1, 1, 2'd1, 1, 2'd1, 1, 2'd1, 0, 0, 0, 2'd3, 2'd3),
         32'hA, 32'h5000, 1, "R10 trap beats return and write");
    doOp(0, 1, 1, mkWord(2'd1, 1, 2'd1, 1, 2'd1, 1, 2'd1, 0, 0, 0, 2'd3, 2'd3),
         32'hB, 32'h6000, 0, "R10 return beats write");
    doOp(1, 0, 1, mkWord(2'd0, 1, 2'd0, 1, 2'd0, 1, 2'd0, 1, 1, 1, 2'd3, 2'd0),
         32'hC, 32'h7000, 0, "R10 trap beats write");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule